// File: doc/BRIEF.md
# Big-Endian Byte-Lane Memory Aligner

This block sits between the load/store stage of a 32-bit pipeline and a word-addressed data memory. It forms the effective byte address from a base register and a signed 16-bit displacement, sends the word address to memory, and converts word and byte requests into four per-byte write enables with write data already placed in the right lanes. Lanes are big-endian. The byte whose address equals the word address sits in the most significant lane, and the byte at offset 3 sits in the least significant lane.

The memory is taken to be synchronous: read data appears one clock after the request. The aligner therefore registers the lane, the access size and the extension mode of each accepted load. In the next cycle it extracts and extends the returned data. A word access whose address is not on a 4-byte boundary is flagged, and the block sends nothing to memory for it.

Top module: `bea_aligner`

## Requirements
- R1: The effective address is `base_i` plus `offset_i` sign-extended to 32 bits. `mem_addr_o` carries bits 31:2 of that address.
- R2: An aligned word load (`op_i`=00) raises `mem_req_o` with `mem_we_o`=0. One cycle later `ld_valid_o` is 1 and `ld_data_o` equals `mem_rdata_i` unchanged.
- R3: An aligned word store (`op_i`=01) raises `mem_req_o` and sets `mem_we_o`=4'b1111, and `mem_wdata_o` equals `st_data_i`.
- R4: Lane order is big-endian. Byte offset k (address bits 1:0 = k) maps to data bits [31-8k:24-8k], and its write enable is `mem_we_o` bit 3-k. Enable bit j covers data bits [8j+7:8j].
- R5: A byte store (`op_i`=11) asserts exactly one write enable, the one of the addressed lane. Every lane of `mem_wdata_o` carries `st_data_i[7:0]`, so the other three bytes of the memory word are left unchanged.
- R6: A byte load (`op_i`=10) with `unsigned_i`=0 returns the addressed byte in bits 7:0 of `ld_data_o`. Bits 31:8 are copies of the byte's bit 7.
- R7: A byte load with `unsigned_i`=1 returns the addressed byte in bits 7:0, with bits 31:8 set to zero.
- R8: A word load or store whose address bits 1:0 are not 00 sets `misalign_o`, holds `mem_req_o` and all write enables low, and yields no `ld_valid_o` in the following cycle.
- R9: Byte loads and byte stores never set `misalign_o`, whatever the address.
- R10: While `rst_ni` is low and in the first cycle after it, `ld_valid_o` is 0.
- R11: With `req_valid_i` low, `mem_req_o`, `mem_we_o` and `misalign_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| op_i | input | 2 | 00 word load, 01 word store, 10 byte load, 11 byte store |
| unsigned_i | input | 1 | Zero-extend byte loads instead of sign-extending them |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| st_data_i | input | 32 | Store source register |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the request |
| mem_addr_o | output | 30 | Word address to memory |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 4 | Per-byte write enables, bit j covers bits 8j+7:8j |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| ld_data_o | output | 32 | Aligned and extended load result |
| ld_valid_o | output | 1 | `ld_data_o` is valid |
| misalign_o | output | 1 | Misaligned word access |

## Verification
The hardest case to reach from the ports is a misaligned word store that must leave memory unchanged. Write enables that are merely low look the same as a write that never mattered. The bench therefore runs the stores through a behavioural memory that honours each lane enable, and it reads the word back afterwards. The same read-back approach shows that a byte store in one lane did not disturb its neighbours. The stimulus also reaches addresses through negative displacements, so the carry of the address adder crosses word boundaries.

// File: rtl/bea_pkg.sv
package bea_pkg;
  typedef enum logic [1:0] {
    OP_LW = 2'b00,
    OP_SW = 2'b01,
    OP_LB = 2'b10,
    OP_SB = 2'b11
  } mem_op_e;
endpackage

// File: rtl/bea_agu.sv
module bea_agu #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0]      base_i,
  input  logic [OFFS_W-1:0]      offset_i,
  input  logic                   valid_i,
  input  logic                   word_i,
  output logic [ADDR_W-LANE_W-1:0] word_addr_o,
  output logic [LANE_W-1:0]      lane_o,
  output logic                   misalign_o
);
  logic [ADDR_W-1:0] ea;

  always_comb begin
    ea          = base_i + {{(ADDR_W-OFFS_W){offset_i[OFFS_W-1]}}, offset_i};
    word_addr_o = ea[ADDR_W-1:LANE_W];
    lane_o      = ea[LANE_W-1:0];
    misalign_o  = valid_i && word_i && (|ea[LANE_W-1:0]);
  end
endmodule

// File: rtl/bea_store_lane.sv
module bea_store_lane #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              store_i,
  input  logic              byte_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [LANES-1:0]  we_o,
  output logic [DATA_W-1:0] wdata_o
);
  // enable bit j holds big-endian lane LANES-1-j
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [LANE_W-1:0] MY_LANE = LANE_W'(LANES - 1 - j);
    always_comb begin
      wdata_o[8*j +: 8] = byte_i ? data_i[7:0] : data_i[8*j +: 8];
      we_o[j]           = store_i && (!byte_i || (lane_i == MY_LANE));
    end
  end
endmodule

// File: rtl/bea_load_lane.sv
module bea_load_lane #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              byte_i,
  input  logic              unsigned_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0] lane_b [LANES];
  logic [7:0] sel_b;

  for (genvar g = 0; g < LANES; g++) begin : g_pick
    assign lane_b[g] = rdata_i[DATA_W-1-8*g -: 8];
  end

  always_comb begin
    sel_b  = lane_b[lane_i];
    data_o = byte_i ? {{(DATA_W-8){!unsigned_i && sel_b[7]}}, sel_b} : rdata_i;
  end
endmodule

// File: rtl/bea_aligner.sv
module bea_aligner #(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [1:0]               op_i,
  input  logic                     unsigned_i,
  input  logic [DATA_W-1:0]        base_i,
  input  logic [OFFS_W-1:0]        offset_i,
  input  logic [DATA_W-1:0]        st_data_i,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic [DATA_W-LANE_W-1:0] mem_addr_o,
  output logic                     mem_req_o,
  output logic [LANES-1:0]         mem_we_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  output logic [DATA_W-1:0]        ld_data_o,
  output logic                     ld_valid_o,
  output logic                     misalign_o
);
  import bea_pkg::*;

  mem_op_e           op;
  logic              is_byte, is_store, go;
  logic [LANE_W-1:0] lane;

  logic              ld_pend_q, ld_byte_q, ld_uns_q;
  logic [LANE_W-1:0] ld_lane_q;

  assign op       = mem_op_e'(op_i);
  assign is_byte  = (op == OP_LB) || (op == OP_SB);
  assign is_store = (op == OP_SW) || (op == OP_SB);

  bea_agu #(.ADDR_W(DATA_W), .OFFS_W(OFFS_W), .LANES(LANES)) u_agu (
    .base_i     (base_i),
    .offset_i   (offset_i),
    .valid_i    (req_valid_i),
    .word_i     (!is_byte),
    .word_addr_o(mem_addr_o),
    .lane_o     (lane),
    .misalign_o (misalign_o)
  );

  assign go        = req_valid_i && !misalign_o;
  assign mem_req_o = go;

  bea_store_lane #(.DATA_W(DATA_W)) u_st (
    .store_i(go && is_store),
    .byte_i (is_byte),
    .lane_i (lane),
    .data_i (st_data_i),
    .we_o   (mem_we_o),
    .wdata_o(mem_wdata_o)
  );

  // load context held across the memory read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pend_q <= 1'b0;
      ld_byte_q <= 1'b0;
      ld_uns_q  <= 1'b0;
      ld_lane_q <= '0;
    end else begin
      ld_pend_q <= go && !is_store;
      if (go && !is_store) begin
        ld_byte_q <= is_byte;
        ld_uns_q  <= unsigned_i;
        ld_lane_q <= lane;
      end
    end
  end

  bea_load_lane #(.DATA_W(DATA_W)) u_ld (
    .rdata_i   (mem_rdata_i),
    .byte_i    (ld_byte_q),
    .unsigned_i(ld_uns_q),
    .lane_i    (ld_lane_q),
    .data_o    (ld_data_o)
  );

  assign ld_valid_o = ld_pend_q;
endmodule

// File: rtl/bea_aligner_chk.sv
module bea_aligner_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [1:0]       op_i,
  input logic             mem_req_o,
  input logic [LANES-1:0] mem_we_o,
  input logic             ld_valid_o,
  input logic             misalign_o
);
  // R8
  misalign_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!mem_req_o && mem_we_o == '0));

  // R8
  misalign_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> !ld_valid_o);

  // R2
  load_returns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !op_i[0] && !misalign_o) |=> ld_valid_o);

  // R5
  byte_store_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 2'b11) |-> ($countones(mem_we_o) == 1));

  // R9
  byte_never_misaligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i[1]) |-> !misalign_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!mem_req_o && mem_we_o == '0 && !misalign_o));

  // R3
  word_store_all_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 2'b01 && !misalign_o) |-> (&mem_we_o));
endmodule

bind bea_aligner bea_aligner_chk #(.LANES(LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .op_i       (op_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .ld_valid_o (ld_valid_o),
  .misalign_o (misalign_o)
);

// File: tb/sim_bea_aligner.sv
`timescale 1ns/1ps
module sim_bea_aligner;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        unsigned_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] st_data_i = '0;
  logic [31:0] mem_rdata_i;
  logic [29:0] mem_addr_o;
  logic        mem_req_o;
  logic [3:0]  mem_we_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] ld_data_o;
  logic        ld_valid_o;
  logic        misalign_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bea_aligner u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .op_i(op_i),
    .unsigned_i(unsigned_i), .base_i(base_i), .offset_i(offset_i),
    .st_data_i(st_data_i), .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .ld_data_o(ld_data_o), .ld_valid_o(ld_valid_o), .misalign_o(misalign_o)
  );

  // behavioural synchronous word memory honouring lane enables
  logic [31:0] mem [16];
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem_rdata_i = '0;
  end
  always @(posedge clk) begin
    if (mem_req_o) begin
      mem_rdata_i <= mem[mem_addr_o[3:0]];
      for (int j = 0; j < 4; j++)
        if (mem_we_o[j]) mem[mem_addr_o[3:0]][8*j +: 8] <= mem_wdata_o[8*j +: 8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic        uns;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        mis;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 1'b0, 32'h100, 16'h0000, 32'h11223344, 32'h0,        1'b0},
    '{2'b00, 1'b0, 32'h104, 16'hFFFC, 32'h0,        32'h11223344, 1'b0},
    '{2'b10, 1'b0, 32'h100, 16'h0000, 32'h0,        32'h00000011, 1'b0},
    '{2'b10, 1'b0, 32'h103, 16'h0000, 32'h0,        32'h00000044, 1'b0},
    '{2'b11, 1'b0, 32'h100, 16'h0001, 32'hFFFFFF9A, 32'h0,        1'b0},
    '{2'b10, 1'b0, 32'h101, 16'h0000, 32'h0,        32'hFFFFFF9A, 1'b0},
    '{2'b10, 1'b1, 32'h101, 16'h0000, 32'h0,        32'h0000009A, 1'b0},
    '{2'b00, 1'b0, 32'h100, 16'h0000, 32'h0,        32'h119A3344, 1'b0},
    '{2'b01, 1'b0, 32'h102, 16'h0000, 32'hDEADBEEF, 32'h0,        1'b1},
    '{2'b00, 1'b0, 32'h100, 16'h0000, 32'h0,        32'h119A3344, 1'b0},
    '{2'b11, 1'b0, 32'h107, 16'h0000, 32'h000000C3, 32'h0,        1'b0},
    '{2'b00, 1'b0, 32'h104, 16'h0000, 32'h0,        32'h000000C3, 1'b0},
    '{2'b10, 1'b0, 32'h107, 16'h0000, 32'h0,        32'hFFFFFFC3, 1'b0},
    '{2'b00, 1'b0, 32'h101, 16'h0000, 32'h0,        32'h0,        1'b1},
    '{2'b10, 1'b0, 32'h10B, 16'hFFF8, 32'h0,        32'h00000044, 1'b0}
  };

  task automatic run_vec(input vec_t v);
    logic [31:0] ea;
    logic [3:0]  exp_we;
    string       tag;
    ea = v.base + {{16{v.off[15]}}, v.off};
    @(negedge clk);
    req_valid_i = 1'b1; op_i = v.op; unsigned_i = v.uns;
    base_i = v.base; offset_i = v.off; st_data_i = v.wd;
    #2;
    chk(mem_addr_o == ea[31:2], "R1", {2'b0, mem_addr_o}, {2'b0, ea[31:2]});
    chk(misalign_o == v.mis, v.op[1] ? "R9" : "R8", {31'b0, misalign_o}, {31'b0, v.mis});
    if (v.mis) exp_we = 4'h0;
    else if (v.op == 2'b01) exp_we = 4'hF;
    else if (v.op == 2'b11) exp_we = 4'b1000 >> ea[1:0];
    else exp_we = 4'h0;
    chk(mem_we_o == exp_we, v.op == 2'b11 ? "R4 R5" : (v.mis ? "R8" : "R3"),
        {28'b0, mem_we_o}, {28'b0, exp_we});
    chk(mem_req_o == !v.mis, v.mis ? "R8" : "R2", {31'b0, mem_req_o}, {31'b0, !v.mis});
    if (v.op == 2'b01 && !v.mis)
      chk(mem_wdata_o == v.wd, "R3", mem_wdata_o, v.wd);
    if (v.op == 2'b11)
      chk(mem_wdata_o[8*(3-ea[1:0]) +: 8] == v.wd[7:0], "R5",
          {24'b0, mem_wdata_o[8*(3-ea[1:0]) +: 8]}, {24'b0, v.wd[7:0]});
    @(negedge clk);
    req_valid_i = 1'b0;
    #2;
    if (!v.op[0]) begin
      if (v.mis) chk(!ld_valid_o, "R8", {31'b0, ld_valid_o}, 32'h0);
      else begin
        tag = (v.op == 2'b00) ? "R2" : (v.uns ? "R7" : "R6 R4");
        chk(ld_valid_o, tag, {31'b0, ld_valid_o}, 32'h1);
        chk(ld_data_o == v.exp, tag, ld_data_o, v.exp);
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R10: held in reset, even with a load presented
    req_valid_i = 1'b1; op_i = 2'b00; base_i = 32'h100;
    @(negedge clk);
    chk(!ld_valid_o, "R10", {31'b0, ld_valid_o}, 32'h0);
    req_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!ld_valid_o, "R10", {31'b0, ld_valid_o}, 32'h0);
    // R11: idle with a store pattern on the inputs
    op_i = 2'b01; base_i = 32'h102; st_data_i = 32'hFFFFFFFF;
    #2;
    chk(!mem_req_o && mem_we_o == 4'h0 && !misalign_o, "R11",
        {27'b0, mem_req_o, mem_we_o}, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9: byte store at every offset, misalign never set, one enable
    for (int k = 0; k < 4; k++)
      run_vec('{2'b11, 1'b0, 32'h120 + k, 16'h0000, 32'h000000A0 + k, 32'h0, 1'b0});
    run_vec('{2'b00, 1'b0, 32'h120, 16'h0000, 32'h0, 32'hA0A1A2A3, 1'b0});
    // R1: negative displacement across a word boundary
    run_vec('{2'b10, 1'b1, 32'h124, 16'hFFFF, 32'h0, 32'h000000A3, 1'b0});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule